// File: doc/BRIEF.md
# Lockable PWM Driver Enable Gate

This block shares one pulse-width waveform across eight driver outputs, four half-bridge and four high-side. A per-driver enable register decides, for each output, whether the output follows the driver's static on/off control alone or that control gated by the waveform. A second register holds the duty value. Both registers sit on a simple byte-wide register bus.

A free-running counter builds the waveform. A new duty value is copied into an applied (shadow) copy only when a period ends, so the waveform never glitches. While the applied duty is nonzero, the enable register is locked against writes. To change the enables, the host writes duty zero, waits for the period to end, and then rewrites the enables. A low-power request clears both registers and the applied copy at once.

Top module: `drvpwm_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `drv_out`, `wr_reject`, `cfg_applied` and `rdata` are all zero, and both registers hold zero.
- R2: The enable register is at address 0x1B and the duty register is at address 0x1A. `rdata` is registered: one clock after `addr` is presented, it shows the stored value of the addressed register, or zero for any other address.
- R3: Enable bit i controls `drv_out[i]`. Bits 3:0 belong to half-bridge drivers 1 to 4 and bits 7:4 to high-side drivers 1 to 4, and any combination may be set at once.
- R4: When an enable bit is 0, the matching `drv_out` bit equals the matching `drv_ctl` bit, delayed by one clock. If all enables are 0, no output is modulated.
- R5: When an enable bit is 1, the output is `drv_ctl` AND the waveform. The waveform is high while the counter is below the applied duty. Over any 256 consecutive cycles, a driver with its control held high is high for exactly `duty` cycles: duty 0 gives constant low and duty 255 gives 255 cycles high.
- R6: The counter starts at 0 when reset releases and counts up by one each clock, wrapping after 255. `cfg_applied` takes the duty register value only on the edge where the counter moves from 255 to 0, first on the 256th clock after reset.
- R7: A write to the enable register while `cfg_applied` is nonzero leaves the register unchanged and produces a one-cycle `wr_reject` pulse on the following cycle. An accepted write produces no pulse.
- R8: Writing 0 to the duty register does not unlock the enable register until `cfg_applied` has become 0 at the next period end.
- R9: A clock with `lp_req` high clears the enable register, the duty register and `cfg_applied`, and any register write in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_req | input | 1 | Low-power mode entry request |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| wr_reject | output | 1 | One-cycle pulse when an enable write is blocked |
| drv_ctl | input | 8 | Static on/off control per driver |
| drv_out | output | 8 | Registered driver outputs |
| cfg_applied | output | 8 | Duty value currently applied to the waveform |

## Verification
The bench builds the block with its default parameters: four half-bridge and four high-side drivers, with an 8-bit counter and duty width. The resulting 256-cycle period is short enough that the bench can count high cycles over whole periods for several enable, duty and control patterns. It can also cross many period boundaries to measure when lock and unlock take effect. The duty extremes 0 and 255 and the exact period-end edge are all reachable within a short run.

// File: rtl/drvpwm_pkg.sv
package drvpwm_pkg;
  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_ENA,
    SEL_DUTY
  } reg_sel_e;
endpackage

// File: rtl/drvpwm_regs.sv
module drvpwm_regs
  import drvpwm_pkg::*;
#(
  parameter int NDRV     = 8,
  parameter int DUTY_W   = 8,
  parameter int BUS_W    = 8,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] ENA_ADDR  = 8'h1B,
  parameter logic [ADDR_W-1:0] DUTY_ADDR = 8'h1A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lp_req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              locked,
  output logic [NDRV-1:0]   ena_q,
  output logic [DUTY_W-1:0] duty_q,
  output logic [BUS_W-1:0]  rdata,
  output logic              wr_reject
);
  reg_sel_e sel;

  always_comb begin
    if (addr == ENA_ADDR)       sel = SEL_ENA;
    else if (addr == DUTY_ADDR) sel = SEL_DUTY;
    else                        sel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q     <= '0;
      duty_q    <= '0;
      wr_reject <= 1'b0;
    end else if (lp_req) begin
      ena_q     <= '0;
      duty_q    <= '0;
      wr_reject <= 1'b0;
    end else begin
      wr_reject <= 1'b0;
      if (wr_en) begin
        case (sel)
          SEL_ENA: begin
            if (locked) wr_reject <= 1'b1;
            else        ena_q     <= wdata[NDRV-1:0];
          end
          SEL_DUTY: duty_q <= wdata[DUTY_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (sel)
        SEL_ENA:  rdata <= BUS_W'(ena_q);
        SEL_DUTY: rdata <= BUS_W'(duty_q);
        default:  rdata <= '0;
      endcase
    end
  end

  assert_lock_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_ENA && locked && !lp_req) |=> ($stable(ena_q) && wr_reject));

  assert_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_ENA && !locked && !lp_req) |=>
      (ena_q == $past(wdata[NDRV-1:0]) && !wr_reject));

  assert_lp_clear_R9: assert property (@(posedge clk) disable iff (rst)
    lp_req |=> (ena_q == '0 && duty_q == '0 && !wr_reject));
endmodule

// File: rtl/drvpwm_timebase.sv
module drvpwm_timebase #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lp_req,
  input  logic [CNT_W-1:0] duty_q,
  output logic [CNT_W-1:0] duty_app,
  output logic             wave
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0] cnt;
  logic             period_end;

  assign period_end = (cnt == CNT_LAST);
  assign wave       = (cnt < duty_app);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      duty_app <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (lp_req)          duty_app <= '0;
      else if (period_end) duty_app <= duty_q;
    end
  end

  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt == CNT_W'($past(cnt) + 1'b1));

  assert_app_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!period_end && !lp_req) |=> $stable(duty_app));

  assert_lp_app_R9: assert property (@(posedge clk) disable iff (rst)
    lp_req |=> duty_app == '0);
endmodule

// File: rtl/drvpwm_gate.sv
module drvpwm_gate #(
  parameter int NDRV = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wave,
  input  logic [NDRV-1:0] drv_en,
  input  logic [NDRV-1:0] drv_ctl,
  output logic [NDRV-1:0] drv_out
);
  for (genvar i = 0; i < NDRV; i++) begin : g_drv
    always_ff @(posedge clk) begin
      if (rst) drv_out[i] <= 1'b0;
      else     drv_out[i] <= drv_ctl[i] & (~drv_en[i] | wave);
    end
  end

  assert_pass_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((drv_out ^ $past(drv_ctl)) & ~$past(drv_en)) == '0);

  assert_mod_R5: assert property (@(posedge clk) disable iff (rst)
    !wave |=> (drv_out & $past(drv_en)) == '0);
endmodule

// File: rtl/drvpwm_top.sv
module drvpwm_top #(
  parameter int NUM_HB = 4,
  parameter int NUM_HS = 4,
  parameter int CNT_W  = 8,
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ENA_ADDR  = 8'h1B,
  parameter logic [ADDR_W-1:0] DUTY_ADDR = 8'h1A
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     lp_req,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BUS_W-1:0]         wdata,
  output logic [BUS_W-1:0]         rdata,
  output logic                     wr_reject,
  input  logic [NUM_HB+NUM_HS-1:0] drv_ctl,
  output logic [NUM_HB+NUM_HS-1:0] drv_out,
  output logic [CNT_W-1:0]         cfg_applied
);
  localparam int NDRV = NUM_HB + NUM_HS;

  logic [NDRV-1:0]  ena_q;
  logic [CNT_W-1:0] duty_q;
  logic [CNT_W-1:0] duty_app;
  logic             wave;
  logic             locked;

  assign locked      = |duty_app;
  assign cfg_applied = duty_app;

  drvpwm_regs #(
    .NDRV(NDRV), .DUTY_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
    .ENA_ADDR(ENA_ADDR), .DUTY_ADDR(DUTY_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .lp_req(lp_req), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .locked(locked), .ena_q(ena_q), .duty_q(duty_q),
    .rdata(rdata), .wr_reject(wr_reject)
  );

  drvpwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .lp_req(lp_req), .duty_q(duty_q),
    .duty_app(duty_app), .wave(wave)
  );

  drvpwm_gate #(.NDRV(NDRV)) u_gate (
    .clk(clk), .rst(rst), .wave(wave), .drv_en(ena_q),
    .drv_ctl(drv_ctl), .drv_out(drv_out)
  );

  assert_reject_lock_R8: assert property (@(posedge clk) disable iff (rst)
    wr_reject |-> $past(duty_app) != '0);
endmodule

// File: tb/drvpwm_top_test.sv
module drvpwm_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lp_req = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       wr_reject;
  logic [7:0] drv_ctl = 8'h00;
  logic [7:0] drv_out;
  logic [7:0] cfg_applied;

  int checks = 0;
  int errors = 0;
  int k = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_ENA  = 8'h1B;
  localparam logic [7:0] A_DUTY = 8'h1A;

  // {enable, duty, control}
  localparam logic [23:0] VEC [5] = '{
    {8'h01, 8'h40, 8'hFF},
    {8'hF0, 8'h80, 8'hFF},
    {8'hA5, 8'hFF, 8'h3C},
    {8'hFF, 8'h00, 8'hFF},
    {8'h00, 8'h10, 8'h5A}
  };

  always #4 clk = ~clk;

  always @(posedge clk) k <= rst ? 0 : k + 1;

  drvpwm_top uut (
    .clk(clk), .rst(rst), .lp_req(lp_req), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wr_reject(wr_reject), .drv_ctl(drv_ctl),
    .drv_out(drv_out), .cfg_applied(cfg_applied)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    @(posedge clk); @(negedge clk);
    d = rdata;
  endtask

  task automatic wait_applied(input logic [7:0] t, output int at_k);
    int n = 0;
    while (cfg_applied !== t && n < 700) begin
      @(negedge clk);
      n++;
    end
    if (n >= 700) chk("R6", "applied duty never reached", cfg_applied, t);
    at_k = k;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int at_k;
    int cnt [8];

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "drv_out in reset", drv_out, 0);
    chk("R1", "wr_reject in reset", wr_reject, 0);
    chk("R1", "cfg_applied in reset", cfg_applied, 0);
    chk("R1", "rdata in reset", rdata, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "cfg_applied after reset", cfg_applied, 0);
    reg_read(A_ENA, rd);  chk("R1", "enable after reset", rd, 0);
    reg_read(A_DUTY, rd); chk("R1", "duty after reset", rd, 0);

    // table of patterns
    for (int v = 0; v < 5; v++) begin
      logic [7:0] ena, duty, ctl;
      {ena, duty, ctl} = VEC[v];
      reg_write(A_DUTY, 8'h00);
      wait_applied(8'h00, at_k);
      reg_write(A_ENA, ena);
      chk("R7", "accepted write raised reject", wr_reject, 0);
      reg_read(A_ENA, rd);  chk("R2", "enable readback", rd, ena);
      reg_write(A_DUTY, duty);
      reg_read(A_DUTY, rd); chk("R2", "duty readback", rd, duty);
      drv_ctl = ctl;
      wait_applied(duty, at_k);
      if (duty != 0) chk("R6", "apply edge modulo period", at_k % 256, 0);
      repeat (2) @(negedge clk);
      for (int i = 0; i < 8; i++) cnt[i] = 0;
      for (int c = 0; c < 256; c++) begin
        for (int i = 0; i < 8; i++) cnt[i] += drv_out[i];
        @(negedge clk);
      end
      for (int i = 0; i < 8; i++) begin
        int exp;
        exp = !ctl[i] ? 0 : (ena[i] ? int'(duty) : 256);
        chk(ena[i] ? "R5/R3" : "R4/R3", $sformatf("vec %0d drv %0d high count", v, i),
            cnt[i], exp);
      end
    end

    // R2 unmapped address
    reg_read(8'h00, rd); chk("R2", "unmapped read", rd, 0);

    // R7 lock while applied duty = 0x10
    reg_write(A_ENA, 8'h33);
    chk("R7", "blocked write pulse", wr_reject, 1);
    @(negedge clk);
    chk("R7", "pulse lasts one cycle", wr_reject, 0);
    reg_read(A_ENA, rd); chk("R7", "blocked write kept value", rd, 8'h00);

    // R8 disable latency
    wait_applied(8'h10, at_k);
    while (k % 256 > 200 || k % 256 < 5) @(negedge clk);
    reg_write(A_DUTY, 8'h00);
    chk("R8", "applied holds before period end", cfg_applied, 8'h10);
    reg_write(A_ENA, 8'h44);
    chk("R8", "still locked after duty 0", wr_reject, 1);
    wait_applied(8'h00, at_k);
    chk("R8", "unlock at period edge", at_k % 256, 0);
    reg_write(A_ENA, 8'h44);
    chk("R8", "write accepted after unlock", wr_reject, 0);
    reg_read(A_ENA, rd); chk("R8", "enable after unlock", rd, 8'h44);

    // R9 low-power entry
    reg_write(A_DUTY, 8'h20);
    wait_applied(8'h20, at_k);
    lp_req = 1'b1; wr_en = 1'b1; addr = A_DUTY; wdata = 8'h77;
    @(posedge clk); @(negedge clk);
    lp_req = 1'b0; wr_en = 1'b0;
    chk("R9", "applied cleared", cfg_applied, 0);
    reg_read(A_ENA, rd);  chk("R9", "enable cleared", rd, 0);
    reg_read(A_DUTY, rd); chk("R9", "duty cleared, write ignored", rd, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule